// File: doc/BRIEF.md
# Hexadecimal Floating-Point Add/Subtract/Compare Unit

This block adds, subtracts or compares two base-16 floating-point numbers. Each number has a sign bit, a 7-bit exponent biased by 64, and a fraction read as hex digits. A high word alone is the short format, with a 24-bit fraction. A high word plus a low word is the long format, with a 56-bit fraction. The surrounding logic presents both operands and the opcode bits, then pulses `start`. It waits for `done` and picks up the result words, the condition code and any exception flags. Taking the interrupt for a flag is left to the caller.

The unit is sequential. Each alignment step shifts one hex digit per clock, and so does each normalization step. The latency therefore depends on the exponent difference and on how many leading zero digits the raw result has. Rounding is replaced by truncation with one hex guard digit kept below the fraction. A zero fraction can raise a significance exception. An unnormalized mode leaves the raw sum unshifted.

Top module: `hfp_adder`

## Requirements
- R1: Operand word layout: sign in bit 31, exponent in bits 30:24, upper 24 fraction bits in bits 23:0; the long format adds a 32-bit low word below. The operand with the smaller exponent is shifted right one hex digit per unit of exponent difference. When no carry or normalization occurs, the result exponent is the larger exponent.
- R2: With `op_long` low, both operand low words have no effect, `res_lo` is 0, and the work below the guard digit is discarded.
- R3: One hex guard digit is carried below the fraction through alignment, the add and normalization. It is removed when the result is stored.
- R4: `op_sub` inverts the sign of operand B. When the effective signs differ, the magnitudes are subtracted. If B has the larger magnitude, the difference is recomplemented and the result sign is the inverse of A's sign.
- R5: A carry out of the fraction shifts the sum right one hex digit and raises the exponent by one.
- R6: If that carry takes the exponent to 128, `exp_ovf` is set and the stored exponent field is 0 (the exponent modulo 128).
- R7: `cc` is 0 when the fraction including the guard digit is zero, 1 when the result is negative, and 2 when it is positive. It is never 3.
- R8: With `op_cmp` high, only `cc` is produced. `res_valid` is low, all three exception flags are low, and `res_hi`/`res_lo` keep their previous values.
- R9: A zero fraction with `mask_sig` high sets `sig_exc` and stores a positive zero fraction with the exponent unchanged.
- R10: A zero fraction with `mask_sig` low stores an all-zero word when normalizing. In unnormalized mode it stores a positive zero fraction with the exponent kept.
- R11: Normalizing operations shift left one hex digit and decrement the exponent while the leading digit is zero. With `op_unnorm` high the raw sum is stored unshifted.
- R12: If normalization drives the exponent below 0, the behaviour depends on `mask_unf`. When it is high, `exp_unf` is set and the stored exponent is the value plus 128. When it is low, the result is an all-zero word with `cc` 0.
- R13: `start` is taken only while `busy` is low; a `start` while busy has no effect. `done` is a one-cycle pulse, and the outputs hold until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken when idle) |
| op_sub | input | 1 | Invert sign of operand B |
| op_cmp | input | 1 | Compare only: set cc, store nothing |
| op_unnorm | input | 1 | Skip post-normalization |
| op_long | input | 1 | 1 = 56-bit fraction, 0 = 24-bit fraction |
| mask_sig | input | 1 | Significance exception enable |
| mask_unf | input | 1 | Exponent-underflow exception enable |
| a_hi | input | 32 | Operand A high word |
| a_lo | input | 32 | Operand A low word |
| b_hi | input | 32 | Operand B high word |
| b_lo | input | 32 | Operand B low word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| res_valid | output | 1 | Result words were written by this operation |
| res_hi | output | 32 | Result high word |
| res_lo | output | 32 | Result low word (0 in short format) |
| cc | output | 2 | Condition code |
| exp_ovf | output | 1 | Exponent overflow |
| exp_unf | output | 1 | Exponent underflow |
| sig_exc | output | 1 | Significance exception |

## Verification
The carry-out right shift and the overflow test happen in the same cycle: the exponent that was just incremented is the one compared against 128. Operands with exponent 127 and the same sign, whose fractions sum to one or more, force both at once. The bench then expects `exp_ovf` set, an exponent field of zero and a normalized fraction. The last normalization shift and the underflow decision are provoked the same way, with small-exponent operands that cancel. Each such case is run with the underflow mask high and low and judged against the wrapped exponent and the forced zero respectively.

// File: rtl/hfp_adder.sv
module hfp_adder #(
  parameter int EXP_W     = 7,
  parameter int HI_FRAC_W = 24,
  parameter int LO_W      = 32,
  parameter int DIG_W     = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic                         op_sub,
  input  logic                         op_cmp,
  input  logic                         op_unnorm,
  input  logic                         op_long,
  input  logic                         mask_sig,
  input  logic                         mask_unf,
  input  logic [HI_FRAC_W+EXP_W:0]     a_hi,
  input  logic [LO_W-1:0]              a_lo,
  input  logic [HI_FRAC_W+EXP_W:0]     b_hi,
  input  logic [LO_W-1:0]              b_lo,
  output logic                         busy,
  output logic                         done,
  output logic                         res_valid,
  output logic [HI_FRAC_W+EXP_W:0]     res_hi,
  output logic [LO_W-1:0]              res_lo,
  output logic [1:0]                   cc,
  output logic                         exp_ovf,
  output logic                         exp_unf,
  output logic                         sig_exc
);
  localparam int WRK_W   = HI_FRAC_W + LO_W + DIG_W;
  localparam int EW      = EXP_W + 2;
  localparam int OVF_EXP = 1 << EXP_W;
  localparam int SGN     = HI_FRAC_W + EXP_W;

  typedef enum logic [1:0] {IDLE, ALIGN, ADD, NORM} st_t;
  st_t st;

  logic [WRK_W-1:0] fa, fb, w;
  logic [EW-1:0]    ea, eb, ew;
  logic             sa, sb, sw, ovf_q;
  logic             cmp_q, unn_q, long_q, msig_q, munf_q;

  wire [WRK_W-1:0] keep    = long_q ? {WRK_W{1'b1}} : {{(HI_FRAC_W+DIG_W){1'b1}}, {LO_W{1'b0}}};
  wire [WRK_W:0]   dif     = {1'b0, fa} - {1'b0, fb};
  wire [WRK_W:0]   sum     = {1'b0, fa} + {1'b0, fb};
  wire             eff_sub = sa ^ sb;
  wire [WRK_W-1:0] mag     = eff_sub ? (dif[WRK_W] ? fb - fa : dif[WRK_W-1:0]) : sum[WRK_W-1:0];
  wire             carry   = !eff_sub && sum[WRK_W];
  wire             rsign   = sa ^ (eff_sub && dif[WRK_W]);
  wire [EW-1:0]    ea_inc  = ea + 1'b1;
  wire             w_zero  = (w == '0);
  wire             lead0   = (w[WRK_W-1 -: DIG_W] == '0);
  wire [1:0]       cc_now  = w_zero ? 2'd0 : (sw ? 2'd1 : 2'd2);
  wire [HI_FRAC_W-1:0] top_frac = w[WRK_W-1 -: HI_FRAC_W];
  wire [LO_W-1:0]  low_frac = long_q ? w[DIG_W +: LO_W] : '0;

  assign busy = (st != IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; done <= 1'b0; res_valid <= 1'b0; res_hi <= '0; res_lo <= '0;
      cc <= '0; exp_ovf <= 1'b0; exp_unf <= 1'b0; sig_exc <= 1'b0;
      fa <= '0; fb <= '0; w <= '0; ea <= '0; eb <= '0; ew <= '0;
      sa <= 1'b0; sb <= 1'b0; sw <= 1'b0; ovf_q <= 1'b0;
      cmp_q <= 1'b0; unn_q <= 1'b0; long_q <= 1'b0; msig_q <= 1'b0; munf_q <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (start) begin
          fa <= {a_hi[HI_FRAC_W-1:0], op_long ? a_lo : {LO_W{1'b0}}, {DIG_W{1'b0}}};
          fb <= {b_hi[HI_FRAC_W-1:0], op_long ? b_lo : {LO_W{1'b0}}, {DIG_W{1'b0}}};
          ea <= EW'(a_hi[SGN-1 -: EXP_W]);
          eb <= EW'(b_hi[SGN-1 -: EXP_W]);
          sa <= a_hi[SGN];
          sb <= b_hi[SGN] ^ op_sub;
          cmp_q <= op_cmp; unn_q <= op_unnorm; long_q <= op_long;
          msig_q <= mask_sig; munf_q <= mask_unf;
          st <= ALIGN;
        end
        ALIGN: begin
          if (ea > eb) begin
            fb <= (fb >> DIG_W) & keep; eb <= eb + 1'b1;
          end else if (eb > ea) begin
            fa <= (fa >> DIG_W) & keep; ea <= ea + 1'b1;
          end else st <= ADD;
        end
        ADD: begin
          sw <= rsign;
          if (carry) begin
            w     <= {{(DIG_W-1){1'b0}}, 1'b1, mag[WRK_W-1:DIG_W]} & keep;
            ew    <= ea_inc;
            ovf_q <= (ea_inc == EW'(OVF_EXP));
          end else begin
            w     <= mag & keep;
            ew    <= ea;
            ovf_q <= 1'b0;
          end
          st <= NORM;
        end
        NORM: begin
          if (cmp_q) begin
            done <= 1'b0 | 1'b1; res_valid <= 1'b0; cc <= cc_now;
            exp_ovf <= 1'b0; exp_unf <= 1'b0; sig_exc <= 1'b0; st <= IDLE;
          end else if (w_zero) begin
            done <= 1'b1; res_valid <= 1'b1; cc <= 2'd0;
            exp_ovf <= 1'b0; exp_unf <= 1'b0; sig_exc <= msig_q;
            res_hi <= {1'b0, (msig_q || unn_q) ? ew[EXP_W-1:0] : {EXP_W{1'b0}}, {HI_FRAC_W{1'b0}}};
            res_lo <= '0; st <= IDLE;
          end else if (!unn_q && lead0) begin
            w <= w << DIG_W; ew <= ew - 1'b1;
          end else begin
            done <= 1'b1; res_valid <= 1'b1; sig_exc <= 1'b0; exp_ovf <= ovf_q; st <= IDLE;
            if (ew[EW-1] && !munf_q) begin
              res_hi <= '0; res_lo <= '0; cc <= 2'd0; exp_unf <= 1'b0;
            end else begin
              res_hi <= {sw, ew[EXP_W-1:0], top_frac};
              res_lo <= low_frac; cc <= cc_now; exp_unf <= ew[EW-1];
            end
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  assert_align_equal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ADD) |-> (ea == eb));
  assert_short_lo_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !long_q) |-> (res_lo == '0));
  assert_ovf_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && exp_ovf) |-> (res_hi[SGN-1 -: EXP_W] == '0));
  assert_cc_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cc != 2'd3));
  assert_cmp_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !res_valid) |-> !(exp_ovf || exp_unf || sig_exc));
  assert_true_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_valid && cc == 2'd0 && !sig_exc && !unn_q) |-> (res_hi == '0));
  assert_norm_lead_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_valid && !unn_q && cc != 2'd0) |-> (res_hi[HI_FRAC_W-1 -: DIG_W] != '0));
  assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/hfp_adder_bench.sv
module hfp_adder_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic op_sub = 0, op_cmp = 0, op_unnorm = 0, op_long = 0, mask_sig = 0, mask_unf = 0;
  logic [31:0] a_hi = 0, a_lo = 0, b_hi = 0, b_lo = 0;
  logic busy, done, res_valid, exp_ovf, exp_unf, sig_exc;
  logic [31:0] res_hi, res_lo;
  logic [1:0] cc;

  always #(CLK_PERIOD/2) clk = ~clk;

  hfp_adder u_hfp_adder (
    .clk(clk), .rst_n(rst_n), .start(start), .op_sub(op_sub), .op_cmp(op_cmp),
    .op_unnorm(op_unnorm), .op_long(op_long), .mask_sig(mask_sig), .mask_unf(mask_unf),
    .a_hi(a_hi), .a_lo(a_lo), .b_hi(b_hi), .b_lo(b_lo), .busy(busy), .done(done),
    .res_valid(res_valid), .res_hi(res_hi), .res_lo(res_lo), .cc(cc),
    .exp_ovf(exp_ovf), .exp_unf(exp_unf), .sig_exc(sig_exc));

  typedef struct {
    logic [31:0] hi, lo;
    logic [1:0]  cc;
    logic        valid, ovf, unf, sig;
    string       tag;
  } item_t;

  item_t sb_q[$];
  int checks = 0, fails = 0;
  logic [31:0] last_hi, last_lo;

  function automatic item_t model(input logic [31:0] ah, al, bh, bl,
                                  input logic sub, cmp, unn, lng, msig, munf);
    item_t r;
    logic [59:0] x, y, m, keep;
    logic [60:0] t;
    int ex, ey, e;
    logic s1, s2, s, cy;
    r.hi = 0; r.lo = 0; r.cc = 0; r.valid = !cmp; r.ovf = 0; r.unf = 0; r.sig = 0; r.tag = "";
    keep = lng ? {60{1'b1}} : {28'hFFFFFFF, 32'h0};
    x = {ah[23:0], lng ? al : 32'h0, 4'h0};
    y = {bh[23:0], lng ? bl : 32'h0, 4'h0};
    ex = int'(ah[30:24]); ey = int'(bh[30:24]);
    while (ex < ey) begin x = (x >> 4) & keep; ex++; end
    while (ey < ex) begin y = (y >> 4) & keep; ey++; end
    s1 = ah[31]; s2 = bh[31] ^ sub; cy = 0;
    if (s1 != s2) begin
      if (x >= y) begin m = x - y; s = s1; end else begin m = y - x; s = !s1; end
    end else begin
      t = {1'b0, x} + {1'b0, y}; m = t[59:0]; cy = t[60]; s = s1;
    end
    e = ex;
    if (cy) begin
      m = {4'h1, m[59:4]} & keep; e++;
      if (e == 128) r.ovf = 1;
    end
    r.cc = (m == 0) ? 2'd0 : (s ? 2'd1 : 2'd2);
    if (cmp) begin r.ovf = 0; return r; end
    if (m == 0) begin
      r.sig = msig;
      r.hi = {1'b0, (msig || unn) ? e[6:0] : 7'd0, 24'h0};
      r.ovf = 0;
      return r;
    end
    if (!unn) while (m[59:56] == 0) begin m = m << 4; e--; end
    if (e < 0) begin
      if (munf) begin r.unf = 1; e += 128; end
      else begin r.hi = 0; r.lo = 0; r.cc = 0; return r; end
    end
    r.hi = {s, e[6:0], m[59:36]};
    r.lo = lng ? m[35:4] : 32'h0;
    return r;
  endfunction

  task automatic check(input string tag, input logic ok, input logic [63:0] act, exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
    end
  endtask

  task automatic run_op(input string tag, input logic [31:0] ah, al, bh, bl,
                        input logic sub, cmp, unn, lng, msig, munf);
    item_t it;
    while (busy) @(negedge clk);
    it = model(ah, al, bh, bl, sub, cmp, unn, lng, msig, munf);
    it.tag = tag;
    sb_q.push_back(it);
    a_hi = ah; a_lo = al; b_hi = bh; b_lo = bl;
    op_sub = sub; op_cmp = cmp; op_unnorm = unn; op_long = lng; mask_sig = msig; mask_unf = munf;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
  endtask

  // monitor: pops the scoreboard at each completion
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb_q.size() == 0) begin
        check("R13 unexpected completion", 1'b0, {32'h0, res_hi}, 64'h0);
      end else begin
        item_t e;
        logic ok;
        e = sb_q.pop_front();
        ok = (res_valid == e.valid) && (cc == e.cc) && (exp_ovf == e.ovf) &&
             (exp_unf == e.unf) && (sig_exc == e.sig);
        if (e.valid) ok = ok && (res_hi == e.hi) && (res_lo == e.lo);
        else ok = ok && (res_hi == last_hi) && (res_lo == last_lo);
        check(e.tag, ok,
              {res_hi, res_lo[15:0], 6'b0, cc, 4'b0, res_valid, exp_ovf, exp_unf, sig_exc},
              {e.valid ? e.hi : last_hi, e.valid ? e.lo[15:0] : last_lo[15:0], 6'b0, e.cc, 4'b0,
               e.valid, e.ovf, e.unf, e.sig});
        last_hi = res_hi; last_lo = res_lo;
      end
    end
  end

  logic timeout = 1'b0;

  initial begin
    last_hi = 0; last_lo = 0;
    fork
      begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R13 reset busy", busy == 0, {63'h0, busy}, 64'h0);
        check("R13 reset done", done == 0, {63'h0, done}, 64'h0);
        check("R7 reset cc/outputs", (cc == 0) && (res_hi == 0) && (res_valid == 0),
              {30'h0, cc, res_hi}, 64'h0);
        // R1 alignment of a smaller-exponent operand
        run_op("R1 align short", 32'h42123456, 0, 32'h41100000, 0, 0,0,0,0,0,0);
        run_op("R1 align long", 32'h43ABCDEF, 32'h12345678, 32'h41FEDCBA, 32'h9ABCDEF0, 0,0,0,1,0,0);
        run_op("R1 align 127 digits", 32'h7F100000, 0, 32'h00100000, 0, 0,0,0,0,0,0);
        // R2 short format ignores low words
        run_op("R2 short low words ignored", 32'h42123456, 32'hFFFFFFFF, 32'h41100000, 32'hDEADBEEF, 0,0,0,0,0,0);
        run_op("R2 short guard truncation", 32'h41100000, 32'h0, 32'h3F123456, 32'h0, 0,0,0,0,0,0);
        // R3 guard digit participates in cancellation
        run_op("R3 guard digit short", 32'h41100000, 0, 32'h40FFFFFF, 0, 1,0,0,0,0,0);
        run_op("R3 guard digit long", 32'h41100000, 0, 32'h40FFFFFF, 32'hFFFFFFFF, 1,0,0,1,0,0);
        // R4 effective sign and recomplement
        run_op("R4 sub recomplement", 32'h41200000, 0, 32'h41300000, 0, 1,0,0,0,0,0);
        run_op("R4 mixed signs", 32'hC1500000, 0, 32'h41200000, 0, 0,0,0,0,0,0);
        run_op("R4 neg minus neg", 32'hC1200000, 0, 32'hC1700000, 0, 1,0,0,0,0,0);
        // R5 carry out
        run_op("R5 carry shift", 32'h41800000, 0, 32'h41800000, 0, 0,0,0,0,0,0);
        run_op("R5 carry long", 32'h42FFFFFF, 32'hFFFFFFFF, 32'h40100000, 32'h0, 0,0,0,1,0,0);
        // R6 overflow with carry in the same step
        run_op("R6 overflow wrap", 32'h7FF00000, 0, 32'h7FF00000, 0, 0,0,0,0,0,0);
        run_op("R6 negative overflow", 32'hFF900000, 0, 32'hFF900000, 0, 0,0,0,0,0,0);
        // R7 cc codes
        run_op("R7 cc positive", 32'h40100000, 0, 32'h40200000, 0, 0,0,0,0,0,0);
        run_op("R7 cc negative", 32'hC0100000, 0, 32'h40050000, 0, 0,0,0,0,0,0);
        // R8 compare only
        run_op("R8 compare less", 32'h41100000, 0, 32'h41200000, 0, 1,1,0,0,0,0);
        run_op("R8 compare equal", 32'h41100000, 0, 32'h41100000, 0, 1,1,0,0,1,0);
        run_op("R8 compare overflowing", 32'h7FF00000, 0, 32'h7FF00000, 0, 0,1,0,0,0,0);
        // R9 significance
        run_op("R9 significance", 32'h41100000, 0, 32'h41100000, 0, 1,0,0,0,1,0);
        // R10 zero without significance mask
        run_op("R10 true zero normalized", 32'hC3123400, 0, 32'hC3123400, 0, 1,0,0,0,0,0);
        run_op("R10 zero unnormalized", 32'h43123400, 0, 32'h43123400, 0, 1,0,1,0,0,0);
        // R11 normalization versus unnormalized
        run_op("R11 normalize", 32'h41100000, 0, 32'h410F0000, 0, 1,0,0,0,0,0);
        run_op("R11 unnormalized kept", 32'h41100000, 0, 32'h410F0000, 0, 1,0,1,0,0,0);
        run_op("R11 normalize long", 32'h44100000, 32'h00000000, 32'h440FFFFF, 32'hFFFFFF00, 1,0,0,1,0,0);
        // R12 underflow
        run_op("R12 underflow masked on", 32'h00100000, 0, 32'h000F0000, 0, 1,0,0,0,0,1);
        run_op("R12 underflow forced zero", 32'h00100000, 0, 32'h000F0000, 0, 1,0,0,0,0,0);
        // R13 start while busy has no effect
        while (busy) @(negedge clk);
        begin
          item_t it;
          it = model(32'h41300000, 0, 32'h41100000, 0, 0,0,0,0,0,0);
          it.tag = "R13 busy start ignored";
          sb_q.push_back(it);
        end
        a_hi = 32'h41300000; a_lo = 0; b_hi = 32'h41100000; b_lo = 0;
        op_sub = 0; op_cmp = 0; op_unnorm = 0; op_long = 0; mask_sig = 0; mask_unf = 0;
        start = 1'b1;
        @(negedge clk);
        a_hi = 32'h7FF00000; b_hi = 32'h7FF00000; op_sub = 1;
        @(negedge clk);
        start = 1'b0;
        while (busy) @(negedge clk);
        repeat (5) @(negedge clk);
        check("R13 outputs held", (res_hi == last_hi) && !done && !busy,
              {res_hi, 29'h0, done, busy, 1'b0}, {last_hi, 32'h0});
        check("R13 scoreboard drained", sb_q.size() == 0, 64'(sb_q.size()), 64'h0);
      end
      begin
        repeat (150000) @(posedge clk);
        timeout = 1'b1;
      end
    join_any
    disable fork;
    if (timeout) check("watchdog expired", 1'b0, 64'h1, 64'h0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule